// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block sits between a processor byte-wide load/store port and a block-oriented memory port. Each 16-bit byte address is broken into a tag, a set index and a byte offset. The two ways of the indexed set are compared in parallel. A hit is answered from the local line store. A miss fetches the whole enclosing block before it completes. Write misses allocate in the same way as read misses, so every write ends up updating a cached line and marking it dirty.

The victim is chosen by a per-set least-recently-used bit. When that victim holds modified data, it is sent to memory before the replacement block is requested. A flush command walks every line and writes back the ones that are still dirty, so memory becomes current at the end of a run.

The processor side uses a valid/ready request channel. A request is taken on a cycle where both `cpu_req_valid` and `cpu_req_ready` are high. Ready stays low until the matching response pulse, so only one access is ever in flight. The memory side has three channels:
- A block request channel under valid/ready.
- A write-beat channel where the controller holds each beat until the memory raises ready.
- A read-beat channel where the memory pushes beats with a valid strobe and the controller always accepts them.

Top module: `wbc_cache`

## Requirements
- R1: Address fields are split as follows. The byte offset is address bits [4:0], the set index is bit [5] and the tag is bits [15:6].
- R2: An access hits only when a valid line of the indexed set holds the same tag. `cpu_rsp_hit` is 1 for an access that hit on first lookup and 0 for one that needed a fetch.
- R3: A read returns the most recent byte value at that address, whether that value was written by the processor or came from memory.
- R4: A write miss fetches the enclosing block, merges the byte into it and leaves the line dirty.
- R5: On a miss, the victim is chosen in this order:
  - an invalid way 0;
  - otherwise an invalid way 1;
  - otherwise the way the set's LRU bit points at.
  Every hit or fill makes the LRU bit point at the other way.
- R6: A dirty victim is written back to its own block address before the new block is requested. A clean or invalid victim causes no writeback.
- R7: Block request rules:
  - `mem_req_valid` stays high, with `mem_req_addr` and `mem_req_we` stable, until the cycle where `mem_req_ready` is high.
  - The address is block-aligned (bits [4:0] zero).
  - `mem_req_we` is 1 for a writeback and 0 for a fetch.
- R8: Beat transfer rules:
  - A block moves as 8 beats of 32 bits, lowest offset first.
  - Byte k of a beat sits at bits [8k+7:8k].
  - A write beat stays on `mem_wdata` with `mem_wvalid` high until `mem_wready`.
  - A read beat is taken on every cycle where `mem_rvalid` is high.
- R9: Ready timing on the processor port:
  - `cpu_req_ready` falls in the cycle after a request is accepted.
  - It stays low until it returns high together with the one-cycle `cpu_rsp_valid` pulse.
- R10: A flush writes back every dirty line in ascending order of line number (set*2 + way), clears the dirty bits and keeps the lines valid. A flush with no dirty lines issues no memory request.
- R11: `flush_start` is taken only while idle and has priority over a request in the same cycle. `cpu_req_ready` is low while `flush_start` is high.
- R12: After reset:
  - every line is invalid;
  - `cpu_req_ready` is high;
  - no memory request and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Byte address |
| cpu_req_wdata | input | 8 | Byte to write |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Access hit on first lookup |
| cpu_rsp_rdata | output | 8 | Read byte (written byte for a write) |
| flush_start | input | 1 | Start writing back all dirty lines |
| mem_req_valid | output | 1 | Block request present |
| mem_req_ready | input | 1 | Memory accepts the block request |
| mem_req_we | output | 1 | 1 = writeback, 0 = fetch |
| mem_req_addr | output | 16 | Block-aligned address |
| mem_wvalid | output | 1 | Writeback beat present |
| mem_wready | input | 1 | Memory takes the writeback beat |
| mem_wdata | output | 32 | Writeback beat |
| mem_rvalid | input | 1 | Fetch beat present |
| mem_rdata | input | 32 | Fetch beat |

## Verification
The hardest case to reach from the ports is eviction of a dirty line whose LRU bit has just been flipped by a hit. Reaching it needs two distinct tags in one set, then a write, then a re-touch of the other way, and only then a third tag.

The stimulus starts with a directed four-access trace that produces exactly this case. It then runs a long arithmetic sweep over five tags, both sets and scattered offsets, with writes mixed in. A shadow model of line state and memory contents predicts every hit flag, read byte and writeback address. Memory-side stalls on every channel exercise the hold rules, and mid-run and final flushes compare the backing store byte for byte against the shadow memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB_REQ,
    ST_WB_BEAT,
    ST_FILL_REQ,
    ST_FILL_BEAT,
    ST_FLUSH_SCAN
  } wbc_state_e;
endpackage

// File: rtl/wbc_addr_split.sv
module wbc_addr_split #(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 1,
  parameter int OFF_W  = 5,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SET_W-1:0]  set_o,
  output logic [OFF_W-1:0]  off_o
);
  // R1: offset lowest, set index above it, tag in the remaining upper bits
  assign off_o = addr_i[OFF_W-1:0];
  assign set_o = addr_i[OFF_W +: SET_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/wbc_tag_cmp.sv
module wbc_tag_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SETS      = 2,
  parameter int BLK_BYTES = 32,
  parameter int BEAT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [7:0]        cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [7:0]        cpu_rsp_rdata,
  input  logic              flush_start,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [BEAT_W-1:0] mem_rdata
);
  // Two ways: the per-set LRU bit names the way to evict next.
  localparam int WAYS       = 2;
  localparam int WAY_W      = 1;
  localparam int OFF_W      = $clog2(BLK_BYTES);
  localparam int SET_W      = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W      = ADDR_W - SET_W - OFF_W;
  localparam int LINES      = SETS * WAYS;
  localparam int LINE_W     = $clog2(LINES);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int BEATS      = BLK_BYTES / BEAT_BYTES;
  localparam int BEAT_CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  wbc_state_e        st_q;
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [7:0]        data_q [LINES][BLK_BYTES];
  logic [SETS-1:0]   lru_q;

  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [7:0]        req_wdata_q;
  logic              miss_q, flushing_q;
  logic [WAY_W-1:0]  way_q;
  logic [LINE_W-1:0] wb_line_q, scan_q;
  logic [BEAT_CW-1:0] beat_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [7:0]        rsp_rdata_q;

  logic [TAG_W-1:0]  r_tag;
  logic [SET_W-1:0]  r_set;
  logic [OFF_W-1:0]  r_off;

  wbc_addr_split #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) split_i (
    .addr_i(req_addr_q), .tag_o(r_tag), .set_o(r_set), .off_o(r_off)
  );

  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            hit_vec;
  logic                       lk_hit;
  logic [WAY_W-1:0]           hit_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w] = valid_q[int'(r_set) * WAYS + w];
      set_tags[w]  = tag_q[int'(r_set) * WAYS + w];
    end
  end

  wbc_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) cmp_i (
    .valid_i(set_valid), .tags_i(set_tags), .tag_i(r_tag),
    .hit_vec_o(hit_vec), .hit_o(lk_hit), .hit_way_o(hit_way)
  );

  // R5: invalid way 0, then invalid way 1, then the LRU pick
  logic [WAY_W-1:0] victim;
  always_comb begin
    if (!set_valid[0])      victim = 1'b0;
    else if (!set_valid[1]) victim = 1'b1;
    else                    victim = lru_q[r_set];
  end

  int hit_line, vic_line, fill_line;
  assign hit_line  = int'(r_set) * WAYS + int'(hit_way);
  assign vic_line  = int'(r_set) * WAYS + int'(victim);
  assign fill_line = int'(r_set) * WAYS + int'(way_q);

  logic [SET_W-1:0] wb_set;
  assign wb_set = SET_W'(wb_line_q >> WAY_W);

  // Port drive
  assign cpu_req_ready = (st_q == ST_IDLE) && !flush_start;
  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_hit   = rsp_hit_q;
  assign cpu_rsp_rdata = rsp_rdata_q;
  assign mem_req_valid = (st_q == ST_WB_REQ) || (st_q == ST_FILL_REQ);
  assign mem_req_we    = (st_q == ST_WB_REQ);
  assign mem_req_addr  = (st_q == ST_WB_REQ) ? {tag_q[wb_line_q], wb_set, {OFF_W{1'b0}}}
                                             : {r_tag, r_set, {OFF_W{1'b0}}};
  assign mem_wvalid    = (st_q == ST_WB_BEAT);

  always_comb begin
    for (int k = 0; k < BEAT_BYTES; k++) begin
      mem_wdata[8*k +: 8] = data_q[wb_line_q][int'(beat_q) * BEAT_BYTES + k];
    end
  end

  logic beat_last;
  assign beat_last = (beat_q == BEAT_CW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      valid_q     <= '0;
      dirty_q     <= '0;
      lru_q       <= '0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      miss_q      <= 1'b0;
      flushing_q  <= 1'b0;
      way_q       <= '0;
      wb_line_q   <= '0;
      scan_q      <= '0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_rdata_q <= '0;
      for (int l = 0; l < LINES; l++) begin
        tag_q[l] <= '0;
        for (int b = 0; b < BLK_BYTES; b++) data_q[l][b] <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (flush_start) begin
            flushing_q <= 1'b1;
            scan_q     <= '0;
            st_q       <= ST_FLUSH_SCAN;
          end else if (cpu_req_valid) begin
            req_we_q    <= cpu_req_we;
            req_addr_q  <= cpu_req_addr;
            req_wdata_q <= cpu_req_wdata;
            miss_q      <= 1'b0;
            st_q        <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (lk_hit) begin
            if (req_we_q) begin
              data_q[hit_line][r_off] <= req_wdata_q;
              dirty_q[hit_line]       <= 1'b1;
              rsp_rdata_q             <= req_wdata_q;
            end else begin
              rsp_rdata_q <= data_q[hit_line][r_off];
            end
            rsp_hit_q    <= !miss_q;
            rsp_valid_q  <= 1'b1;
            lru_q[r_set] <= ~hit_way;
            st_q         <= ST_IDLE;
          end else begin
            miss_q    <= 1'b1;
            way_q     <= victim;
            wb_line_q <= LINE_W'(vic_line);
            st_q      <= (valid_q[vic_line] && dirty_q[vic_line]) ? ST_WB_REQ : ST_FILL_REQ;
          end
        end
        ST_WB_REQ: begin
          if (mem_req_ready) begin
            beat_q <= '0;
            st_q   <= ST_WB_BEAT;
          end
        end
        ST_WB_BEAT: begin
          if (mem_wready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_last) begin
              dirty_q[wb_line_q] <= 1'b0;
              st_q <= flushing_q ? ST_FLUSH_SCAN : ST_FILL_REQ;
            end
          end
        end
        ST_FILL_REQ: begin
          if (mem_req_ready) begin
            beat_q <= '0;
            st_q   <= ST_FILL_BEAT;
          end
        end
        ST_FILL_BEAT: begin
          if (mem_rvalid) begin
            for (int k = 0; k < BEAT_BYTES; k++) begin
              data_q[fill_line][int'(beat_q) * BEAT_BYTES + k] <= mem_rdata[8*k +: 8];
            end
            beat_q <= beat_q + 1'b1;
            if (beat_last) begin
              valid_q[fill_line] <= 1'b1;
              dirty_q[fill_line] <= 1'b0;
              tag_q[fill_line]   <= r_tag;
              st_q               <= ST_LOOKUP;
            end
          end
        end
        ST_FLUSH_SCAN: begin
          if (valid_q[scan_q] && dirty_q[scan_q]) begin
            wb_line_q <= scan_q;
            st_q      <= ST_WB_REQ;
          end else if (scan_q == LINE_W'(LINES - 1)) begin
            flushing_q <= 1'b0;
            st_q       <= ST_IDLE;
          end else begin
            scan_q <= scan_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  p_wbeat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_wdata));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  p_single_way_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_wb_only_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) && mem_req_we |-> dirty_q[wb_line_q] && valid_q[wb_line_q]);

  p_flush_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !flush_start);
endmodule

// File: tb/wbc_cache_tb_top.sv
module wbc_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_we = 1'b0;
  logic [15:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_rsp_valid, cpu_rsp_hit;
  logic [7:0]  cpu_rsp_rdata;
  logic        flush_start = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_we;
  logic [15:0] mem_req_addr;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wbc_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .flush_start(flush_start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int gap_ctr = 0;

  logic [7:0] store  [int];
  logic [7:0] shadow [int];
  int         wb_log [$];

  int ref_valid [4];
  int ref_dirty [4];
  int ref_tag   [4];
  int ref_lru   [2];

  function automatic logic [7:0] init_byte(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] store_rd(int a);
    return store.exists(a) ? store[a] : init_byte(a);
  endfunction

  function automatic logic [7:0] shadow_rd(int a);
    return shadow.exists(a) ? shadow[a] : init_byte(a);
  endfunction

  function automatic bit stall_now();
    gap_ctr++;
    return (gap_ctr % 5) == 3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder (R7, R8): address handshake, then 8 little-endian beats
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        bit is_wb;
        int base;
        is_wb = mem_req_we;
        base  = int'(mem_req_addr);
        chk(mem_req_addr[4:0] == 5'd0, "R7 aligned request", int'(mem_req_addr[4:0]), 0);
        if (stall_now()) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (is_wb) wb_log.push_back(base);
        for (int b = 0; b < 8; b++) begin
          if (stall_now()) begin
            mem_wready = 1'b0;
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          if (is_wb) begin
            mem_wready = 1'b1;
            for (int k = 0; k < 4; k++) store[base + 4*b + k] = mem_wdata[8*k +: 8];
          end else begin
            mem_rvalid = 1'b1;
            for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = store_rd(base + 4*b + k);
          end
          @(negedge clk);
        end
        mem_wready = 1'b0;
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic access(bit we, int a, logic [7:0] d);
    int rt, rs, hw, li, exp_wb;
    bit exp_hit;
    logic [7:0] exp_rd;
    rt = a >> 6;
    rs = (a >> 5) & 1;
    hw = -1;
    exp_wb = -1;
    for (int w = 0; w < 2; w++)
      if (ref_valid[rs*2+w] != 0 && ref_tag[rs*2+w] == rt) hw = w;
    exp_hit = (hw >= 0);
    if (hw < 0) begin
      int v;
      if (ref_valid[rs*2] == 0)        v = 0;
      else if (ref_valid[rs*2+1] == 0) v = 1;
      else                             v = ref_lru[rs];
      li = rs*2 + v;
      if (ref_valid[li] != 0 && ref_dirty[li] != 0) exp_wb = (ref_tag[li] << 6) | (rs << 5);
      ref_valid[li] = 1;
      ref_tag[li]   = rt;
      ref_dirty[li] = 0;
      hw = v;
    end
    li = rs*2 + hw;
    if (we) begin
      ref_dirty[li] = 1;
      shadow[a] = d;
    end
    ref_lru[rs] = 1 - hw;
    exp_rd = shadow_rd(a);

    wb_log.delete();
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = 16'(a);
    cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(cpu_req_ready == 1'b0, "R9 busy after accept", int'(cpu_req_ready), 0);
    while (!cpu_rsp_valid) @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R9 ready with response", int'(cpu_req_ready), 1);
    chk(cpu_rsp_hit == exp_hit, "R1/R2/R5 hit flag", int'(cpu_rsp_hit), int'(exp_hit));
    if (!we) chk(cpu_rsp_rdata == exp_rd, "R3/R4/R8 read data", int'(cpu_rsp_rdata), int'(exp_rd));
    if (exp_wb >= 0)
      chk(wb_log.size() == 1 && wb_log[0] == exp_wb, "R6 dirty victim writeback",
          (wb_log.size() > 0) ? wb_log[0] : -1, exp_wb);
    else
      chk(wb_log.size() == 0, "R6 no writeback of clean victim", wb_log.size(), 0);
  endtask

  task automatic flush_all();
    int exp_list [$];
    for (int l = 0; l < 4; l++)
      if (ref_valid[l] != 0 && ref_dirty[l] != 0) exp_list.push_back((ref_tag[l] << 6) | ((l >> 1) << 5));
    wb_log.delete();
    while (!cpu_req_ready) @(negedge clk);
    flush_start = 1'b1;
    #1;
    chk(cpu_req_ready == 1'b0, "R11 ready low during flush_start", int'(cpu_req_ready), 0);
    @(negedge clk);
    flush_start = 1'b0;
    while (!cpu_req_ready) @(negedge clk);
    chk(wb_log.size() == exp_list.size(), "R10 flush writeback count", wb_log.size(), exp_list.size());
    for (int i = 0; i < exp_list.size() && i < wb_log.size(); i++)
      chk(wb_log[i] == exp_list[i], "R10 flush order", wb_log[i], exp_list[i]);
    for (int l = 0; l < 4; l++) ref_dirty[l] = 0;
    foreach (shadow[k])
      chk(store_rd(k) == shadow[k], "R10/R8 memory after flush", int'(store_rd(k)), int'(shadow[k]));
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin
      ref_valid[l] = 0; ref_dirty[l] = 0; ref_tag[l] = 0;
    end
    ref_lru[0] = 0; ref_lru[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R12 ready after reset", int'(cpu_req_ready), 1);
    chk(mem_req_valid == 1'b0, "R12 no memory request", int'(mem_req_valid), 0);
    chk(cpu_rsp_valid == 1'b0, "R12 no response", int'(cpu_rsp_valid), 0);

    // Directed trace: fetch, fetch, hit, dirty eviction, then flush of one block
    access(1'b0, 16'h00a0, 8'h00);
    access(1'b1, 16'h00f4, 8'hC3);
    access(1'b0, 16'h00b0, 8'h00);
    access(1'b1, 16'h2a2c, 8'h7E);
    flush_all();
    flush_all();   // R10: nothing dirty, no request

    // Sweep over five tags, both sets, scattered offsets
    begin
      int tags [5];
      tags[0] = 0; tags[1] = 1; tags[2] = 2; tags[3] = 16'h2a; tags[4] = 16'h3ff;
      for (int i = 0; i < 240; i++) begin
        int a;
        a = (tags[(i*7 + i/5) % 5] << 6) | (((i*3 + i/7) % 2) << 5) | ((i*13) % 32);
        access((i % 3) == 0, a, 8'(i*29 + 3));
        if (i == 120) flush_all();
      end
    end
    flush_all();
    flush_all();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule